// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

Two single-word message registers let two independently clocked ports pass a word to each other without going through the bulk queues. The A side deposits words into the first mailbox and collects words from the second; the B side does the reverse. Each mailbox carries an active-low "full" flag that lives in the writer's clock domain. The flag drops on the writer's edge that stores a word. It stays low until the reader has consumed the word and that event has crossed back to the writer's clock.

Each port also owns the output path for its direction of the bulk queue. A per-port select line chooses whether that port's read data comes from its incoming mailbox or from the queue output word, which enters the block as an input. The two ports read their direction line with opposite senses: A writes when the line is high, B writes when it is low. A port drives its data output, and raises its enable, only in its read state with its chip select asserted.

The mailbox flag works as the ready half of a valid/ready pair. A mailbox write is offered when chip select, write state and mailbox select are all active. It is taken only on an edge where the flag is high, and an offer made while the flag is low is dropped rather than held. Events cross between the clocks through toggle signals and two-stage synchronisers. Data becomes visible to the reader two reader edges after the write, and the flag returns high two writer edges after the consuming read.

Top module: `dual_clk_mailbox`

## Requirements
- R1: A rising edge of clk_a with cs_a_n=0, wr_rd_a=1, mbx_sel_a=1 and mb1_full_n=1 stores din_a into mailbox 1, and mb1_full_n reads 0 after that edge.
- R2: While mb1_full_n is 0, further mailbox-1 writes from port A are ignored and the stored word is kept unchanged.
- R3: Once mailbox 1 is full, a port-B read (cs_b_n=0, wr_rd_b=1, mbx_sel_b=1) presents the stored word on dout_b. Within four clk_b edges after that read, plus four clk_a edges, mb1_full_n returns to 1.
- R4: Mailbox 2 works the same way with the roles swapped. A port-B write (cs_b_n=0, wr_rd_b=0, mbx_sel_b=1) with mb2_full_n=1 stores din_b and drives mb2_full_n to 0. A port-A read (cs_a_n=0, wr_rd_a=0, mbx_sel_a=1) presents it on dout_a and later returns mb2_full_n to 1.
- R5: While oe_a is 1, dout_a equals mailbox 2 when mbx_sel_a=1 and equals fifo2_dout when mbx_sel_a=0.
- R6: While oe_b is 1, dout_b equals mailbox 1 when mbx_sel_b=1 and equals fifo1_dout when mbx_sel_b=0.
- R7: oe_a is 1 only when cs_a_n=0 and wr_rd_a=0, and oe_b is 1 only when cs_b_n=0 and wr_rd_b=1. Whenever a port's enable is 0, that port's data output is all zeros.
- R8: rst1_n low asynchronously forces mb1_full_n to 1 and clears mailbox 1 to zero, leaving mailbox 2 untouched. rst2_n does the same for mailbox 2.
- R9: A mailbox read while the matching flag is 1 (no unread word) has no effect: the flag stays 1 and the next write is still accepted.
- R10: A write with the mailbox select low, or with chip select high, leaves the mailbox flag and contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst1_n | input | 1 | Asynchronous active-low reset of mailbox 1 (A to B direction) |
| rst2_n | input | 1 | Asynchronous active-low reset of mailbox 2 (B to A direction) |
| cs_a_n | input | 1 | Port A chip select, active low |
| wr_rd_a | input | 1 | Port A direction: 1 write, 0 read |
| mbx_sel_a | input | 1 | Port A mailbox select |
| din_a | input | DW | Port A write data |
| fifo2_dout | input | DW | Queue output word for the B to A direction |
| dout_a | output | DW | Port A read data |
| oe_a | output | 1 | Port A output enable |
| cs_b_n | input | 1 | Port B chip select, active low |
| wr_rd_b | input | 1 | Port B direction: 0 write, 1 read |
| mbx_sel_b | input | 1 | Port B mailbox select |
| din_b | input | DW | Port B write data |
| fifo1_dout | input | DW | Queue output word for the A to B direction |
| dout_b | output | DW | Port B read data |
| oe_b | output | 1 | Port B output enable |
| mb1_full_n | output | 1 | Mailbox 1 full flag, active low, clk_a domain |
| mb2_full_n | output | 1 | Mailbox 2 full flag, active low, clk_b domain |

## Verification
The assertions check on every writer edge that an accepted write drops the flag and that the flag never drops without one. They also check that stored words hold still while a flag is low, that the read multiplexers and the quiet output follow the select lines, and that each reset forces its flag high. The bench's scenarios cover what spans both clocks. They show the word arriving intact at the far port and the flag coming back only after a consuming read. They also show that a premature read, a reset of one mailbox, and writes without mailbox select or chip select leave the other state alone.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DW_DEF   = 36;
  localparam int unsigned MBX_SYNC_DEF = 2;
endpackage

// File: rtl/mbx_sync.sv
// Multi-stage synchroniser for one level signal.
module mbx_sync #(
  parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
// One mailbox: storage and flag on the writer clock, consume event on the reader clock.
module mbx_channel #(
  parameter int unsigned DW   = mbx_pkg::MBX_DW_DEF,
  parameter int unsigned SYNC = mbx_pkg::MBX_SYNC_DEF
) (
  input  logic          clk_w,
  input  logic          clk_r,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic          full_n,
  output logic [DW-1:0] mbx_q
);
  logic put_tgl;    // flips on each accepted write (writer domain)
  logic take_tgl;   // flips on each consuming read (reader domain)
  logic take_seen;  // take_tgl seen in writer domain
  logic put_seen;   // put_tgl seen in reader domain
  logic unread;     // reader sees a word not yet consumed

  always_ff @(posedge clk_w or negedge rst_n) begin
    if (!rst_n) begin
      put_tgl <= 1'b0;
      mbx_q   <= '0;
    end else if (wr_req && full_n) begin
      put_tgl <= ~put_tgl;
      mbx_q   <= wr_data;
    end
  end

  mbx_sync #(.STAGES(SYNC)) u_take_sync (
    .clk(clk_w), .rst_n(rst_n), .d(take_tgl), .q(take_seen)
  );

  assign full_n = (put_tgl == take_seen);

  mbx_sync #(.STAGES(SYNC)) u_put_sync (
    .clk(clk_r), .rst_n(rst_n), .d(put_tgl), .q(put_seen)
  );

  assign unread = (put_seen != take_tgl);

  always_ff @(posedge clk_r or negedge rst_n) begin
    if (!rst_n)                take_tgl <= 1'b0;
    else if (rd_req && unread) take_tgl <= ~take_tgl;
  end
endmodule

// File: rtl/mbx_port.sv
// Port decode: direction polarity, output enable and read-data steering.
module mbx_port #(
  parameter int unsigned DW       = mbx_pkg::MBX_DW_DEF,
  parameter bit          WR_LEVEL = 1'b1
) (
  input  logic          cs_n,
  input  logic          wr_rd,
  input  logic          mbx_sel,
  input  logic [DW-1:0] mbx_data,
  input  logic [DW-1:0] fifo_data,
  output logic          wr_req,
  output logic          rd_req,
  output logic          oe,
  output logic [DW-1:0] dout
);
  logic is_wr;
  logic active;

  generate
    if (WR_LEVEL) begin : g_wr_high
      assign is_wr = wr_rd;
    end else begin : g_wr_low
      assign is_wr = ~wr_rd;
    end
  endgenerate

  assign active = ~cs_n;
  assign wr_req = active & is_wr & mbx_sel;
  assign oe     = active & ~is_wr;
  assign rd_req = oe & mbx_sel;

  always_comb begin
    if (!oe)         dout = '0;
    else if (mbx_sel) dout = mbx_data;
    else             dout = fifo_data;
  end
endmodule

// File: rtl/dual_clk_mailbox.sv
module dual_clk_mailbox #(
  parameter int unsigned DW   = mbx_pkg::MBX_DW_DEF,
  parameter int unsigned SYNC = mbx_pkg::MBX_SYNC_DEF
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst1_n,
  input  logic          rst2_n,
  input  logic          cs_a_n,
  input  logic          wr_rd_a,
  input  logic          mbx_sel_a,
  input  logic [DW-1:0] din_a,
  input  logic [DW-1:0] fifo2_dout,
  output logic [DW-1:0] dout_a,
  output logic          oe_a,
  input  logic          cs_b_n,
  input  logic          wr_rd_b,
  input  logic          mbx_sel_b,
  input  logic [DW-1:0] din_b,
  input  logic [DW-1:0] fifo1_dout,
  output logic [DW-1:0] dout_b,
  output logic          oe_b,
  output logic          mb1_full_n,
  output logic          mb2_full_n
);
  logic          a_wr, a_rd, b_wr, b_rd;
  logic [DW-1:0] mail1_q, mail2_q;

  mbx_port #(.DW(DW), .WR_LEVEL(1'b1)) u_port_a (
    .cs_n(cs_a_n), .wr_rd(wr_rd_a), .mbx_sel(mbx_sel_a),
    .mbx_data(mail2_q), .fifo_data(fifo2_dout),
    .wr_req(a_wr), .rd_req(a_rd), .oe(oe_a), .dout(dout_a)
  );

  mbx_port #(.DW(DW), .WR_LEVEL(1'b0)) u_port_b (
    .cs_n(cs_b_n), .wr_rd(wr_rd_b), .mbx_sel(mbx_sel_b),
    .mbx_data(mail1_q), .fifo_data(fifo1_dout),
    .wr_req(b_wr), .rd_req(b_rd), .oe(oe_b), .dout(dout_b)
  );

  mbx_channel #(.DW(DW), .SYNC(SYNC)) u_ch1 (
    .clk_w(clk_a), .clk_r(clk_b), .rst_n(rst1_n),
    .wr_req(a_wr), .wr_data(din_a), .rd_req(b_rd),
    .full_n(mb1_full_n), .mbx_q(mail1_q)
  );

  mbx_channel #(.DW(DW), .SYNC(SYNC)) u_ch2 (
    .clk_w(clk_b), .clk_r(clk_a), .rst_n(rst2_n),
    .wr_req(b_wr), .wr_data(din_b), .rd_req(a_rd),
    .full_n(mb2_full_n), .mbx_q(mail2_q)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned DW = 36
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst1_n,
  input logic          rst2_n,
  input logic          cs_a_n,
  input logic          wr_rd_a,
  input logic          mbx_sel_a,
  input logic          cs_b_n,
  input logic          wr_rd_b,
  input logic          mbx_sel_b,
  input logic          oe_a,
  input logic          oe_b,
  input logic [DW-1:0] dout_a,
  input logic [DW-1:0] dout_b,
  input logic          mb1_full_n,
  input logic          mb2_full_n,
  input logic [DW-1:0] mail1,
  input logic [DW-1:0] mail2
);
  logic put1, put2;
  assign put1 = !cs_a_n &&  wr_rd_a && mbx_sel_a;
  assign put2 = !cs_b_n && !wr_rd_b && mbx_sel_b;

  p_write_clears_r1: assert property (@(posedge clk_a) disable iff (!rst1_n)
    (put1 && mb1_full_n) |=> !mb1_full_n);

  p_hold_while_full_r2: assert property (@(posedge clk_a) disable iff (!rst1_n)
    !mb1_full_n |=> $stable(mail1));

  p_write_clears_r4: assert property (@(posedge clk_b) disable iff (!rst2_n)
    (put2 && mb2_full_n) |=> !mb2_full_n);

  p_hold_while_full2_r4: assert property (@(posedge clk_b) disable iff (!rst2_n)
    !mb2_full_n |=> $stable(mail2));

  p_mux_a_r5: assert property (@(posedge clk_a) disable iff (!rst2_n)
    (oe_a && mbx_sel_a) |-> (dout_a == mail2));

  p_mux_b_r6: assert property (@(posedge clk_b) disable iff (!rst1_n)
    (oe_b && mbx_sel_b) |-> (dout_b == mail1));

  p_quiet_a_r7: assert property (@(posedge clk_a) disable iff (!rst2_n)
    !oe_a |-> (dout_a == '0));

  p_quiet_b_r7: assert property (@(posedge clk_b) disable iff (!rst1_n)
    !oe_b |-> (dout_b == '0));

  p_no_spurious1_r10: assert property (@(posedge clk_a) disable iff (!rst1_n)
    (mb1_full_n && !put1) |=> mb1_full_n);

  p_no_spurious2_r10: assert property (@(posedge clk_b) disable iff (!rst2_n)
    (mb2_full_n && !put2) |=> mb2_full_n);

  always @(posedge clk_a) begin
    if (rst1_n === 1'b0) begin
      p_reset1_r8: assert (mb1_full_n);
    end
  end

  always @(posedge clk_b) begin
    if (rst2_n === 1'b0) begin
      p_reset2_r8: assert (mb2_full_n);
    end
  end
endmodule

bind dual_clk_mailbox mbx_checker #(.DW(DW)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst1_n(rst1_n), .rst2_n(rst2_n),
  .cs_a_n(cs_a_n), .wr_rd_a(wr_rd_a), .mbx_sel_a(mbx_sel_a),
  .cs_b_n(cs_b_n), .wr_rd_b(wr_rd_b), .mbx_sel_b(mbx_sel_b),
  .oe_a(oe_a), .oe_b(oe_b), .dout_a(dout_a), .dout_b(dout_b),
  .mb1_full_n(mb1_full_n), .mb2_full_n(mb2_full_n),
  .mail1(mail1_q), .mail2(mail2_q)
);

// File: tb/dual_clk_mailbox_bench.sv
`timescale 1ns/1ps
module dual_clk_mailbox_bench;
  localparam int unsigned DW = 36;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst1_n, rst2_n;
  logic cs_a_n, wr_rd_a, mbx_sel_a, cs_b_n, wr_rd_b, mbx_sel_b;
  logic [DW-1:0] din_a, din_b, fifo1_dout, fifo2_dout, dout_a, dout_b;
  logic oe_a, oe_b, mb1_full_n, mb2_full_n;

  int total = 0;
  int bad = 0;

  logic [DW-1:0] sb1_q[$];
  logic [DW-1:0] sb2_q[$];

  always #2.0 clk_a = ~clk_a;   // 250 MHz
  always #3.5 clk_b = ~clk_b;

  dual_clk_mailbox #(.DW(DW)) u_dual_clk_mailbox (
    .clk_a(clk_a), .clk_b(clk_b), .rst1_n(rst1_n), .rst2_n(rst2_n),
    .cs_a_n(cs_a_n), .wr_rd_a(wr_rd_a), .mbx_sel_a(mbx_sel_a), .din_a(din_a),
    .fifo2_dout(fifo2_dout), .dout_a(dout_a), .oe_a(oe_a),
    .cs_b_n(cs_b_n), .wr_rd_b(wr_rd_b), .mbx_sel_b(mbx_sel_b), .din_b(din_b),
    .fifo1_dout(fifo1_dout), .dout_b(dout_b), .oe_b(oe_b),
    .mb1_full_n(mb1_full_n), .mb2_full_n(mb2_full_n)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_a();
    cs_a_n = 1'b1; wr_rd_a = 1'b0; mbx_sel_a = 1'b0;
  endtask

  task automatic idle_b();
    cs_b_n = 1'b1; wr_rd_b = 1'b1; mbx_sel_b = 1'b0;
  endtask

  // Driver: offers a mailbox-1 word; the scoreboard takes it only if the box is empty.
  task automatic put_a(input logic [DW-1:0] d);
    @(negedge clk_a);
    cs_a_n = 1'b0; wr_rd_a = 1'b1; mbx_sel_a = 1'b1; din_a = d;
    if (sb1_q.size() == 0) sb1_q.push_back(d);
    @(negedge clk_a);
    idle_a();
  endtask

  task automatic put_b(input logic [DW-1:0] d);
    @(negedge clk_b);
    cs_b_n = 1'b0; wr_rd_b = 1'b0; mbx_sel_b = 1'b1; din_b = d;
    if (sb2_q.size() == 0) sb2_q.push_back(d);
    @(negedge clk_b);
    idle_b();
  endtask

  // Monitor side: consume mailbox 1 at port B and compare with the scoreboard head.
  task automatic take_b(input string tag);
    logic [DW-1:0] exp;
    repeat (4) @(negedge clk_b);
    cs_b_n = 1'b0; wr_rd_b = 1'b1; mbx_sel_b = 1'b1;
    #0.5;
    exp = (sb1_q.size() != 0) ? sb1_q.pop_front() : '0;
    chk(tag, dout_b, exp);
    @(negedge clk_b);
    idle_b();
    repeat (4) @(negedge clk_a);
    chk({tag, " flag back high (R3)"}, {35'd0, mb1_full_n}, 36'd1);
  endtask

  task automatic take_a(input string tag);
    logic [DW-1:0] exp;
    repeat (4) @(negedge clk_a);
    cs_a_n = 1'b0; wr_rd_a = 1'b0; mbx_sel_a = 1'b1;
    #0.5;
    exp = (sb2_q.size() != 0) ? sb2_q.pop_front() : '0;
    chk(tag, dout_a, exp);
    @(negedge clk_a);
    idle_a();
    repeat (4) @(negedge clk_b);
    chk({tag, " flag2 back high (R4)"}, {35'd0, mb2_full_n}, 36'd1);
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst1_n = 1'b0; rst2_n = 1'b0;
    idle_a(); idle_b();
    din_a = '0; din_b = '0;
    fifo1_dout = 36'hF_1111_0001;
    fifo2_dout = 36'hF_2222_0002;
    #40;
    @(negedge clk_a);
    rst1_n = 1'b1; rst2_n = 1'b1;
    #1;
    // R8 / R7: reset state
    chk("R8 mb1_full_n after reset", {35'd0, mb1_full_n}, 36'd1);
    chk("R8 mb2_full_n after reset", {35'd0, mb2_full_n}, 36'd1);
    chk("R7 oe_a idle", {35'd0, oe_a}, 36'd0);
    chk("R7 dout_b idle", dout_b, '0);

    // R9: premature read of mailbox 1 must not release anything
    @(negedge clk_b);
    cs_b_n = 1'b0; wr_rd_b = 1'b1; mbx_sel_b = 1'b1;
    repeat (2) @(negedge clk_b);
    idle_b();
    repeat (5) @(negedge clk_a);
    chk("R9 flag stays high after empty read", {35'd0, mb1_full_n}, 36'd1);

    // R1: write lowers the flag
    put_a(36'h1_2345_6789);
    chk("R1 mb1_full_n low after write", {35'd0, mb1_full_n}, 36'd0);
    // R2: write while full is ignored
    put_a(36'hD_EAD0_BEEF);
    chk("R2 flag still low", {35'd0, mb1_full_n}, 36'd0);
    take_b("R3 mailbox1 word at port B (R2 keeps first)");

    // Several words through mailbox 1
    for (int i = 0; i < 4; i++) begin
      put_a(36'hA_0000_0000 | (36'(i) * 36'h1_0101));
      take_b("R3 stream word");
    end

    // R4: mailbox 2 round trip
    put_b(36'h5_5AA5_33CC);
    chk("R4 mb2_full_n low after write", {35'd0, mb2_full_n}, 36'd0);
    put_b(36'h0_0000_0BAD);
    chk("R4 second write ignored, still low", {35'd0, mb2_full_n}, 36'd0);
    take_a("R4 mailbox2 word at port A");

    // R5 / R6: read steering
    @(negedge clk_a);
    cs_a_n = 1'b0; wr_rd_a = 1'b0; mbx_sel_a = 1'b0;
    #0.5;
    chk("R5 dout_a from fifo2", dout_a, fifo2_dout);
    chk("R7 oe_a in read state", {35'd0, oe_a}, 36'd1);
    mbx_sel_a = 1'b1;
    #0.5;
    chk("R5 dout_a from mailbox2", dout_a, 36'h5_5AA5_33CC);
    idle_a();
    @(negedge clk_b);
    cs_b_n = 1'b0; wr_rd_b = 1'b1; mbx_sel_b = 1'b0;
    #0.5;
    chk("R6 dout_b from fifo1", dout_b, fifo1_dout);
    idle_b();

    // R7: write state keeps outputs quiet; R10: non-mailbox writes do nothing
    @(negedge clk_a);
    cs_a_n = 1'b0; wr_rd_a = 1'b1; mbx_sel_a = 1'b0; din_a = 36'h7_7777_7777;
    #0.5;
    chk("R7 oe_a low in write state", {35'd0, oe_a}, 36'd0);
    chk("R7 dout_a zero in write state", dout_a, '0);
    @(negedge clk_a);
    cs_a_n = 1'b1; wr_rd_a = 1'b1; mbx_sel_a = 1'b1;
    @(negedge clk_a);
    idle_a();
    chk("R10 flag1 high after non-mailbox writes", {35'd0, mb1_full_n}, 36'd1);
    @(negedge clk_b);
    cs_b_n = 1'b0; wr_rd_b = 1'b0; mbx_sel_b = 1'b0; din_b = 36'h6_6666_6666;
    #0.5;
    chk("R7 oe_b low in write state", {35'd0, oe_b}, 36'd0);
    @(negedge clk_b);
    idle_b();
    chk("R10 flag2 high after fifo-only write", {35'd0, mb2_full_n}, 36'd1);

    // R8: reset of mailbox 1 alone
    put_a(36'h3_3333_3333);
    put_b(36'h4_4444_4444);
    repeat (4) @(negedge clk_b);
    @(negedge clk_a);
    rst1_n = 1'b0;
    repeat (3) @(negedge clk_a);
    rst1_n = 1'b1;
    sb1_q.delete();
    #0.5;
    chk("R8 flag1 high after its reset", {35'd0, mb1_full_n}, 36'd1);
    chk("R8 flag2 untouched by rst1_n", {35'd0, mb2_full_n}, 36'd0);
    @(negedge clk_b);
    cs_b_n = 1'b0; wr_rd_b = 1'b1; mbx_sel_b = 1'b1;
    #0.5;
    chk("R8 mailbox1 cleared", dout_b, '0);
    idle_b();
    take_a("R8 mailbox2 survives rst1_n");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule